// File: doc/BRIEF.md
# Inverting Registered Bus Transceiver

This block sits between a board-side bus, whose signals are active low, and a module-side bus, whose signals are active high. It carries four paths through registers clocked by the chip clock. A 24-bit data word goes from board to module and another from module to board. A 2-bit request goes from module to board. A 4-input OR reduction goes from module to board. Every registered output is the bitwise complement of the value the register captured. A small debug bus is passed through in both directions without a register, so that it keeps working while the pipeline is frozen.

Debug controls set the pipeline mode:
- **Freeze** stalls every pipeline register.
- **Debug reset** loads the reset state.
- **Debug reset with execute** turns the pipeline into a single-step machine that advances once per rising edge of a strobe.

A synchronous stop input parks the board-to-module register after a fixed slip of two words. A registered per-group send mask decides which 6-bit groups of the module-to-board word are driven. A group that is not driven reads as all ones.

The data paths have no valid/ready handshake and no back-pressure: a word is taken on every enabled clock edge. The only flow control is the stop input, and it acts on the board-to-module direction only.

Top module: `bus_xcvr_pipe`

## Requirements
- R1: One rising edge with `rst_n` low sets the following outputs, and they stay there while `rst_n` is low:
  - `mod_data_o` is 0.
  - `brd_data_n_o` is all ones.
  - `brd_req_n_o` is 2'b11.
  - `brd_or_n_o` is 1.
- R2: In run mode (freeze and debug reset both high), one edge after an input is presented:
  - `mod_data_o` equals the complement of `brd_data_n_i`.
  - `brd_req_n_o` equals the complement of `mod_req_i`.
- R3: The send mask `send_i` is captured at the same edge as `mod_data_i`. Send bit g enables output bits 6g+5 down to 6g, so bit 0 enables bits 5:0. An enabled group shows the complement of the captured module data.
- R4: A group whose captured send bit is 0 reads all ones on `brd_data_n_o`.
- R5: `brd_or_n_o` is 1 exactly when all four captured OR inputs are 0. The OR register keeps sampling while debug reset is active.
- R6: The debug paths have no register:
  - `dbg_mod_o` is the complement of `dbg_brd_n_i`.
  - `dbg_brd_n_o` is the complement of `dbg_mod_i` when `dbg_oe_i` is 1, and 3'b111 when it is 0.
- R7: While `dbg_freeze_n_i` is low, the data, request and OR registers hold their values. Freeze takes precedence over debug reset and execute.
- R8: With freeze high, `dbg_reset_n_i` low and `dbg_exec_i` low, each edge loads the R1 values into the data and request paths.
- R9: The stop input is delayed through two registers. After `sstop_n_i` is sampled low, that word and the next one still reach `mod_data_o`, and the register then holds. After release, the hold lasts two more edges.
- R10: With freeze high, debug reset low and `dbg_exec_i` high, the pipeline advances only at an edge where `dbg_strobe_i` is 1 and was 0 at the previous edge. At every other edge it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, rising edge |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| brd_data_n_i | input | 24 | Board data in, active low |
| mod_data_o | output | 24 | Module data out |
| mod_data_i | input | 24 | Module data in |
| brd_data_n_o | output | 24 | Board data out, active low, ones when not driven |
| mod_req_i | input | 2 | Module request in |
| brd_req_n_o | output | 2 | Board request out, active low |
| mod_or_i | input | 4 | Module OR inputs |
| brd_or_n_o | output | 1 | Active-low OR of the captured OR inputs |
| send_i | input | 4 | Per-group drive enable for board data out |
| sstop_n_i | input | 1 | Synchronous stop, active low |
| dbg_freeze_n_i | input | 1 | Debug freeze, active low |
| dbg_reset_n_i | input | 1 | Debug reset, active low |
| dbg_exec_i | input | 1 | Execute: step on strobe edges while in debug reset |
| dbg_strobe_i | input | 1 | Step strobe |
| dbg_brd_n_i | input | 3 | Board debug lines in, active low |
| dbg_mod_o | output | 3 | Module debug lines out |
| dbg_mod_i | input | 3 | Module debug lines in |
| dbg_oe_i | input | 1 | Enable for board debug lines out |
| dbg_brd_n_o | output | 3 | Board debug lines out, active low |

## Verification
The assertions assume that every input, strobe and stop included, is synchronous to `clk` and free of unknowns. The assertions on stop and step rely on `rst_n` having been high at the preceding edges that they look back to. The bench meets these assumptions by changing inputs 2 ns after a rising edge and holding `rst_n` low for two edges before releasing it. It never lets the strobe or the stop change at the sampling instant.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_CLEAR = 2'd2
  } pipe_mode_e;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze_n_i,
  input  logic       dreset_n_i,
  input  logic       exec_i,
  input  logic       strobe_i,
  input  logic       sstop_n_i,
  output pipe_mode_e mode_o,
  output logic       stop_hold_o
);
  logic [1:0] stop_pipe;
  logic       strobe_q;
  logic       strobe_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_pipe <= '0;
      strobe_q  <= 1'b0;
    end else begin
      stop_pipe <= {stop_pipe[0], ~sstop_n_i};
      strobe_q  <= strobe_i;
    end
  end

  assign strobe_rise = strobe_i & ~strobe_q;
  assign stop_hold_o = stop_pipe[1];

  always_comb begin
    if (!freeze_n_i)      mode_o = MODE_HOLD;
    else if (!dreset_n_i) mode_o = exec_i ? (strobe_rise ? MODE_RUN : MODE_HOLD) : MODE_CLEAR;
    else                  mode_o = MODE_RUN;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int REQ_W  = 2,
  parameter int OR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pipe_mode_e        mode_i,
  input  logic              stop_hold_i,
  input  logic [DATA_W-1:0] brd_data_n_i,
  input  logic [DATA_W-1:0] mod_data_i,
  input  logic [REQ_W-1:0]  mod_req_i,
  input  logic [OR_W-1:0]   mod_or_i,
  output logic [DATA_W-1:0] b2m_q_o,
  output logic [DATA_W-1:0] m2b_q_o,
  output logic [REQ_W-1:0]  req_q_o,
  output logic [OR_W-1:0]   or_q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b2m_q_o <= '1;
      m2b_q_o <= '0;
      req_q_o <= '0;
      or_q_o  <= '0;
    end else begin
      case (mode_i)
        MODE_CLEAR: begin
          b2m_q_o <= '1;
          m2b_q_o <= '0;
          req_q_o <= '0;
          or_q_o  <= mod_or_i;
        end
        MODE_RUN: begin
          if (!stop_hold_i) b2m_q_o <= brd_data_n_i;
          m2b_q_o <= mod_data_i;
          req_q_o <= mod_req_i;
          or_q_o  <= mod_or_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int DATA_W = 24,
  parameter int GRP_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_N-1:0]  send_i,
  input  logic [DATA_W-1:0] m2b_q_i,
  output logic [DATA_W-1:0] brd_data_n_o
);
  localparam int GRP_W = DATA_W / GRP_N;
  logic [GRP_N-1:0] send_q;

  always_ff @(posedge clk) begin
    if (!rst_n) send_q <= '0;
    else        send_q <= send_i;
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign brd_data_n_o[g*GRP_W +: GRP_W] =
      send_q[g] ? ~m2b_q_i[g*GRP_W +: GRP_W] : {GRP_W{1'b1}};
  end
endmodule

// File: rtl/bus_xcvr_pipe.sv
module bus_xcvr_pipe
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int GRP_N  = 4,
  parameter int REQ_W  = 2,
  parameter int OR_W   = 4,
  parameter int DBG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] brd_data_n_i,
  output logic [DATA_W-1:0] mod_data_o,
  input  logic [DATA_W-1:0] mod_data_i,
  output logic [DATA_W-1:0] brd_data_n_o,
  input  logic [REQ_W-1:0]  mod_req_i,
  output logic [REQ_W-1:0]  brd_req_n_o,
  input  logic [OR_W-1:0]   mod_or_i,
  output logic              brd_or_n_o,
  input  logic [GRP_N-1:0]  send_i,
  input  logic              sstop_n_i,
  input  logic              dbg_freeze_n_i,
  input  logic              dbg_reset_n_i,
  input  logic              dbg_exec_i,
  input  logic              dbg_strobe_i,
  input  logic [DBG_W-1:0]  dbg_brd_n_i,
  output logic [DBG_W-1:0]  dbg_mod_o,
  input  logic [DBG_W-1:0]  dbg_mod_i,
  input  logic              dbg_oe_i,
  output logic [DBG_W-1:0]  dbg_brd_n_o
);
  pipe_mode_e        mode;
  logic              stop_hold;
  logic [DATA_W-1:0] b2m_q;
  logic [DATA_W-1:0] m2b_q;
  logic [REQ_W-1:0]  req_q;
  logic [OR_W-1:0]   or_q;

  xcvr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze_n_i  (dbg_freeze_n_i),
    .dreset_n_i  (dbg_reset_n_i),
    .exec_i      (dbg_exec_i),
    .strobe_i    (dbg_strobe_i),
    .sstop_n_i   (sstop_n_i),
    .mode_o      (mode),
    .stop_hold_o (stop_hold)
  );

  xcvr_datapath #(.DATA_W(DATA_W), .REQ_W(REQ_W), .OR_W(OR_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .stop_hold_i  (stop_hold),
    .brd_data_n_i (brd_data_n_i),
    .mod_data_i   (mod_data_i),
    .mod_req_i    (mod_req_i),
    .mod_or_i     (mod_or_i),
    .b2m_q_o      (b2m_q),
    .m2b_q_o      (m2b_q),
    .req_q_o      (req_q),
    .or_q_o       (or_q)
  );

  xcvr_drive #(.DATA_W(DATA_W), .GRP_N(GRP_N)) u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .send_i       (send_i),
    .m2b_q_i      (m2b_q),
    .brd_data_n_o (brd_data_n_o)
  );

  assign mod_data_o  = ~b2m_q;
  assign brd_req_n_o = ~req_q;
  assign brd_or_n_o  = ~(|or_q);
  assign dbg_mod_o   = ~dbg_brd_n_i;
  assign dbg_brd_n_o = dbg_oe_i ? ~dbg_mod_i : {DBG_W{1'b1}};
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int DATA_W = 24,
  parameter int REQ_W  = 2,
  parameter int OR_W   = 4,
  parameter int GRP_N  = 4,
  parameter int DBG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] mod_data_o,
  input logic [DATA_W-1:0] brd_data_n_o,
  input logic [REQ_W-1:0]  brd_req_n_o,
  input logic              brd_or_n_o,
  input logic [REQ_W-1:0]  mod_req_i,
  input logic [OR_W-1:0]   mod_or_i,
  input logic [GRP_N-1:0]  send_i,
  input logic              sstop_n_i,
  input logic              dbg_freeze_n_i,
  input logic              dbg_reset_n_i,
  input logic              dbg_exec_i,
  input logic              dbg_strobe_i,
  input logic              dbg_oe_i,
  input logic [DBG_W-1:0]  dbg_brd_n_o
);
  AST_REQ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze_n_i && dbg_reset_n_i) |=> brd_req_n_o == ~$past(mod_req_i)); // R2

  AST_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (send_i == '0) |=> brd_data_n_o == '1); // R4

  AST_OR_IN_DRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze_n_i && !dbg_reset_n_i && !dbg_exec_i) |=> brd_or_n_o == ~(|$past(mod_or_i))); // R5

  AST_DBG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_oe_i |-> dbg_brd_n_o == '1); // R6

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_freeze_n_i |=> ($stable(mod_data_o) && $stable(brd_req_n_o) && $stable(brd_or_n_o))); // R7

  AST_DRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_freeze_n_i && !dbg_reset_n_i && !dbg_exec_i) |=> (mod_data_o == '0 && brd_req_n_o == '1)); // R8

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && $past(!sstop_n_i, 2) && dbg_freeze_n_i && dbg_reset_n_i)
      |=> $stable(mod_data_o)); // R9

  AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dbg_freeze_n_i && !dbg_reset_n_i && dbg_exec_i && !(dbg_strobe_i && !$past(dbg_strobe_i)))
      |=> ($stable(mod_data_o) && $stable(brd_req_n_o))); // R10
endmodule

bind bus_xcvr_pipe xcvr_chk #(
  .DATA_W(DATA_W), .REQ_W(REQ_W), .OR_W(OR_W), .GRP_N(GRP_N), .DBG_W(DBG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_data_o(mod_data_o), .brd_data_n_o(brd_data_n_o),
  .brd_req_n_o(brd_req_n_o), .brd_or_n_o(brd_or_n_o), .mod_req_i(mod_req_i),
  .mod_or_i(mod_or_i), .send_i(send_i), .sstop_n_i(sstop_n_i),
  .dbg_freeze_n_i(dbg_freeze_n_i), .dbg_reset_n_i(dbg_reset_n_i),
  .dbg_exec_i(dbg_exec_i), .dbg_strobe_i(dbg_strobe_i), .dbg_oe_i(dbg_oe_i),
  .dbg_brd_n_o(dbg_brd_n_o)
);

// File: tb/sim_bus_xcvr_pipe.sv
`timescale 1ns/1ps
module sim_bus_xcvr_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] brd_data_n_i, mod_data_o, mod_data_i, brd_data_n_o;
  logic [1:0]  mod_req_i, brd_req_n_o;
  logic [3:0]  mod_or_i, send_i;
  logic        brd_or_n_o, sstop_n_i;
  logic        dbg_freeze_n_i, dbg_reset_n_i, dbg_exec_i, dbg_strobe_i, dbg_oe_i;
  logic [2:0]  dbg_brd_n_i, dbg_mod_o, dbg_mod_i, dbg_brd_n_o;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // {brd_data_n_i[24], mod_data_i[24], mod_req_i[2], mod_or_i[4]}
  localparam int NV = 6;
  localparam logic [53:0] VEC [NV] = '{
    {24'h000000, 24'hFFFFFF, 2'b00, 4'h0},
    {24'hFFFFFF, 24'h000000, 2'b11, 4'h1},
    {24'h555555, 24'hAAAAAA, 2'b01, 4'h8},
    {24'h123456, 24'h89ABCD, 2'b10, 4'h0},
    {24'h800001, 24'h7FFFFE, 2'b00, 4'hF},
    {24'h0F0F0F, 24'hC3C3C3, 2'b11, 4'h4}
  };

  always #5 clk = ~clk;

  bus_xcvr_pipe u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; brd_data_n_i = 24'h0; mod_data_i = 24'h0; mod_req_i = 0; mod_or_i = 0;
    send_i = 0; sstop_n_i = 1; dbg_freeze_n_i = 1; dbg_reset_n_i = 1; dbg_exec_i = 0;
    dbg_strobe_i = 0; dbg_oe_i = 0; dbg_brd_n_i = 0; dbg_mod_i = 0;
    tick(); tick();
    chk("R1 mod_data", {8'h0, mod_data_o}, 32'h0);
    chk("R1 brd_data", {8'h0, brd_data_n_o}, 32'hFFFFFF);
    chk("R1 req", {30'h0, brd_req_n_o}, 32'h3);
    chk("R1 or", {31'h0, brd_or_n_o}, 32'h1);
    rst_n = 1; send_i = 4'hF;
    tick();

    // vector table in run mode
    for (int i = 0; i < NV; i++) begin
      brd_data_n_i = VEC[i][53:30]; mod_data_i = VEC[i][29:6];
      mod_req_i = VEC[i][5:4]; mod_or_i = VEC[i][3:0];
      tick();
      chk("R2 mod_data", {8'h0, mod_data_o}, {8'h0, ~VEC[i][53:30]});
      chk("R3 brd_data", {8'h0, brd_data_n_o}, {8'h0, ~VEC[i][29:6]});
      chk("R2 req", {30'h0, brd_req_n_o}, {30'h0, ~VEC[i][5:4]});
      chk("R5 or", {31'h0, brd_or_n_o}, {31'h0, (VEC[i][3:0] == 4'h0)});
    end

    // send groups
    mod_data_i = 24'hFFFFFF; send_i = 4'b0001; tick();
    chk("R3 group0", {8'h0, brd_data_n_o}, 32'hFFFFC0);
    send_i = 4'b1000; tick();
    chk("R3 group3", {8'h0, brd_data_n_o}, 32'h03FFFF);
    send_i = 4'b0000; tick();
    chk("R4 undriven", {8'h0, brd_data_n_o}, 32'hFFFFFF);
    send_i = 4'hF;

    // debug pass-through
    dbg_brd_n_i = 3'b101; dbg_mod_i = 3'b110; dbg_oe_i = 1; #1;
    chk("R6 dbg_mod", {29'h0, dbg_mod_o}, 32'h2);
    chk("R6 dbg_brd on", {29'h0, dbg_brd_n_o}, 32'h1);
    dbg_oe_i = 0; #1;
    chk("R6 dbg_brd off", {29'h0, dbg_brd_n_o}, 32'h7);

    // freeze
    brd_data_n_i = 24'h111111; mod_req_i = 2'b01; mod_or_i = 4'h2; tick();
    dbg_freeze_n_i = 0; brd_data_n_i = 24'h222222; mod_req_i = 2'b10; mod_or_i = 4'h0;
    tick(); tick();
    chk("R7 frz mod_data", {8'h0, mod_data_o}, 32'hEEEEEE);
    chk("R7 frz req", {30'h0, brd_req_n_o}, 32'h2);
    chk("R7 frz or", {31'h0, brd_or_n_o}, 32'h0);
    dbg_reset_n_i = 0; tick();
    chk("R7 frz over reset", {8'h0, mod_data_o}, 32'hEEEEEE);

    // debug reset
    dbg_freeze_n_i = 1; mod_or_i = 4'h4; mod_data_i = 24'h123456; tick();
    chk("R8 mod_data", {8'h0, mod_data_o}, 32'h0);
    chk("R8 req", {30'h0, brd_req_n_o}, 32'h3);
    chk("R8 brd_data", {8'h0, brd_data_n_o}, 32'hFFFFFF);
    chk("R5 or in reset", {31'h0, brd_or_n_o}, 32'h0);

    // execute stepping
    dbg_exec_i = 1; brd_data_n_i = 24'h00FF00; tick(); tick();
    chk("R10 no strobe", {8'h0, mod_data_o}, 32'h0);
    dbg_strobe_i = 1; tick();
    chk("R10 step1", {8'h0, mod_data_o}, 32'hFF00FF);
    brd_data_n_i = 24'h0000F0; tick();
    chk("R10 level only", {8'h0, mod_data_o}, 32'hFF00FF);
    dbg_strobe_i = 0; tick();
    dbg_strobe_i = 1; tick();
    chk("R10 step2", {8'h0, mod_data_o}, 32'hFFFF0F);
    dbg_strobe_i = 0; dbg_exec_i = 0; dbg_reset_n_i = 1; tick();

    // synchronous stop: word k is k*0x010101
    brd_data_n_i = 24'h0A0A0A; tick();
    brd_data_n_i = 24'h0B0B0B; sstop_n_i = 0; tick();
    chk("R9 slip1", {8'h0, mod_data_o}, 32'hF4F4F4);
    brd_data_n_i = 24'h0C0C0C; tick();
    chk("R9 slip2", {8'h0, mod_data_o}, 32'hF3F3F3);
    brd_data_n_i = 24'h0D0D0D; tick();
    chk("R9 hold", {8'h0, mod_data_o}, 32'hF3F3F3);
    brd_data_n_i = 24'h0E0E0E; sstop_n_i = 1; tick();
    chk("R9 hold rel1", {8'h0, mod_data_o}, 32'hF3F3F3);
    brd_data_n_i = 24'h0F0F0F; tick();
    chk("R9 hold rel2", {8'h0, mod_data_o}, 32'hF3F3F3);
    brd_data_n_i = 24'h101010; tick();
    chk("R9 resume", {8'h0, mod_data_o}, 32'hEFEFEF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule